// File: doc/BRIEF.md
# ADC Input Autoscan Channel Sequencer

This block is the digital control for a four-input sampling converter. A five-bit selection code from the control register picks one of two things. It can pick a fixed input: one single-ended input, or one differential pair. It can also pick an autoscan order that repeats and may mix single-ended and differential entries. On each conversion strobe the block reports the input that the strobe sampled, then moves on to the next entry of the order. It raises a one-cycle start flag when the strobe sampled the first entry of a cycle.

A two-bit test-mode field can replace the converted sample with codes derived from the reference levels: full scale, mid scale or zero. A processor can use these known words to check its data link to the converter. Reserved selection codes hold the converter on single-ended A+ and set an error flag. The flag stays set until a write with a valid code.

Top module: `adc_scan_seq`

## Requirements
- R1: While `rst` is high, and after it falls, the outputs are `sel_src`=0, `sel_diff`=0, `seq_start`=0, `result`=0 and `cfg_err`=0. The stored code is 00000 and the test mode is 00.
- R2: A code (cfg_wdata[4:0], register bits 7:3) of 00000, 00001, 00010 or 00011 selects single-ended A+, A-, B+ or B- on every strobe. These are reported as `sel_src` 0, 1, 2, 3 with `sel_diff`=0.
- R3: Code 00100 selects differential pair A, reported as `sel_src`=0 with `sel_diff`=1. Code 00101 selects differential pair B, reported as `sel_src`=2 with `sel_diff`=1. `sel_diff` is never 1 while `sel_src` is odd.
- R4: Code 10001 repeats A+, A-. Code 10010 repeats A+, A-, B+. Code 10011 repeats A+, A-, B+, B-.
- R5: Code 10101 repeats A+, diff B. Code 10110 repeats A+, A-, diff B. Code 11001 repeats diff A, diff B.
- R6: Every other code is reserved. A write of a reserved code sets `cfg_err` on the next cycle, and strobes then report single-ended A+. A later write of a valid code clears `cfg_err`. `cfg_err` changes only after a write.
- R7: Every write restarts the order at its first entry. A strobe in the same cycle as a write is ignored and leaves the outputs unchanged.
- R8: `seq_start` is high for exactly the one cycle after a strobe that sampled the first entry of the order. It is therefore high after every strobe for a fixed selection.
- R9: `sel_src`, `sel_diff` and `result` change only in the cycle after an accepted strobe, and hold between strobes.
- R10: The test mode (cfg_wdata[6:5], register bits 9:8) sets the `result` word captured at a strobe: 00 gives `raw_data`, 01 gives 0xFFF, 10 gives 0x800 and 11 gives 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 7 | [6:5] test mode, [4:0] selection code |
| conv_strobe | input | 1 | Conversion strobe, one per sample |
| raw_data | input | 12 | Converted sample |
| sel_src | output | 2 | Selected input: 0 A+, 1 A-, 2 B+, 3 B- |
| sel_diff | output | 1 | 1 when the selection is a differential pair |
| seq_start | output | 1 | Strobe sampled the first entry of the order |
| result | output | 12 | Sample or test word |
| cfg_err | output | 1 | Last written code was reserved |

## Verification
Every result appears one clock after the edge that accepts its input. The selection, start flag and result word follow a strobe by one cycle. The error flag, the restart of the order and the new test mode follow a write by one cycle, and the test mode becomes visible at the next strobe. The bench drives inputs on the falling edge and updates its behavioural model on the rising edge from the same values. It then compares every output on the next falling edge, so each comparison falls exactly one edge after its cause. Idle cycles between strobes are compared as well, which checks that the outputs hold.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    localparam int MAX_SEQ = 4;
    localparam int IDX_W   = $clog2(MAX_SEQ);
    localparam int LEN_W   = IDX_W + 1;
    localparam int CODE_W  = 5;
    localparam int TM_W    = 2;

    typedef enum logic [1:0] {
        SRC_AP = 2'd0,
        SRC_AM = 2'd1,
        SRC_BP = 2'd2,
        SRC_BM = 2'd3
    } src_e;

    typedef enum logic [TM_W-1:0] {
        TM_NORMAL = 2'd0,
        TM_POS    = 2'd1,
        TM_MID    = 2'd2,
        TM_NEG    = 2'd3
    } test_mode_e;

    typedef struct packed {
        logic diff;
        src_e src;
    } entry_t;

    typedef struct packed {
        logic                      reserved;
        logic [LEN_W-1:0]          len;
        entry_t [MAX_SEQ-1:0]      ent;
    } scan_cfg_t;

    function automatic entry_t mk_ent(input logic d, input src_e s);
        entry_t e;
        e.diff = d;
        e.src  = s;
        return e;
    endfunction

endpackage

// File: rtl/scan_decode.sv
module scan_decode
    import adc_scan_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output scan_cfg_t         cfg
);
    localparam entry_t E_AP = '{diff: 1'b0, src: SRC_AP};
    localparam entry_t E_AM = '{diff: 1'b0, src: SRC_AM};
    localparam entry_t E_BP = '{diff: 1'b0, src: SRC_BP};
    localparam entry_t E_BM = '{diff: 1'b0, src: SRC_BM};
    localparam entry_t E_DA = '{diff: 1'b1, src: SRC_AP};
    localparam entry_t E_DB = '{diff: 1'b1, src: SRC_BP};

    always_comb begin
        cfg          = '0;
        cfg.len      = LEN_W'(1);
        cfg.ent[0]   = E_AP;
        unique case (code)
            5'b00000: cfg.ent[0] = E_AP;
            5'b00001: cfg.ent[0] = E_AM;
            5'b00010: cfg.ent[0] = E_BP;
            5'b00011: cfg.ent[0] = E_BM;
            5'b00100: cfg.ent[0] = E_DA;
            5'b00101: cfg.ent[0] = E_DB;
            5'b10001: begin
                cfg.len    = LEN_W'(2);
                cfg.ent[1] = E_AM;
            end
            5'b10010: begin
                cfg.len    = LEN_W'(3);
                cfg.ent[1] = E_AM;
                cfg.ent[2] = E_BP;
            end
            5'b10011: begin
                cfg.len    = LEN_W'(4);
                cfg.ent[1] = E_AM;
                cfg.ent[2] = E_BP;
                cfg.ent[3] = E_BM;
            end
            5'b10101: begin
                cfg.len    = LEN_W'(2);
                cfg.ent[1] = E_DB;
            end
            5'b10110: begin
                cfg.len    = LEN_W'(3);
                cfg.ent[1] = E_AM;
                cfg.ent[2] = E_DB;
            end
            5'b11001: begin
                cfg.len    = LEN_W'(2);
                cfg.ent[0] = E_DA;
                cfg.ent[1] = E_DB;
            end
            default: cfg.reserved = 1'b1;
        endcase
    end
endmodule

// File: rtl/scan_index.sv
module scan_index
    import adc_scan_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    input  logic [LEN_W-1:0] len,
    output logic [IDX_W-1:0] idx
);
    logic [LEN_W-1:0] idx_inc;

    assign idx_inc = {1'b0, idx} + LEN_W'(1);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            idx <= '0;
        end else if (adv) begin
            idx <= (idx_inc >= len) ? '0 : idx_inc[IDX_W-1:0];
        end
    end

    // R7: the index stays inside the active order
    assert_idx_in_range_R7: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, idx} < len));

    // R7: a write restarts the order
    assert_clear_restarts_R7: assert property (@(posedge clk) disable iff (rst)
        clr |=> (idx == '0));
endmodule

// File: rtl/test_mux.sv
module test_mux
    import adc_scan_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  test_mode_e        mode,
    input  logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] word
);
    localparam logic [DATA_W-1:0] W_POS = '1;
    localparam logic [DATA_W-1:0] W_MID = DATA_W'(1) << (DATA_W - 1);
    localparam logic [DATA_W-1:0] W_NEG = '0;

    always_comb begin
        unique case (mode)
            TM_POS:  word = W_POS;
            TM_MID:  word = W_MID;
            TM_NEG:  word = W_NEG;
            default: word = raw;
        endcase
    end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [6:0]        cfg_wdata,
    input  logic              conv_strobe,
    input  logic [DATA_W-1:0] raw_data,
    output logic [1:0]        sel_src,
    output logic              sel_diff,
    output logic              seq_start,
    output logic [DATA_W-1:0] result,
    output logic              cfg_err
);
    localparam int TM_LSB = CODE_W;

    logic [CODE_W-1:0] code_q;
    test_mode_e        tmode_q;
    scan_cfg_t         dec;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] word;
    entry_t            sel_q;
    logic              start_q;
    logic              err_q;
    logic [DATA_W-1:0] res_q;
    logic              take;

    assign take = conv_strobe && !cfg_we;

    scan_decode u_dec (
        .code (code_q),
        .cfg  (dec)
    );

    scan_index u_idx (
        .clk (clk),
        .rst (rst),
        .clr (cfg_we),
        .adv (take),
        .len (dec.len),
        .idx (idx)
    );

    test_mux #(.DATA_W(DATA_W)) u_tm (
        .mode (tmode_q),
        .raw  (raw_data),
        .word (word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q  <= '0;
            tmode_q <= TM_NORMAL;
            err_q   <= 1'b0;
        end else if (cfg_we) begin
            code_q  <= cfg_wdata[CODE_W-1:0];
            tmode_q <= test_mode_e'(cfg_wdata[TM_LSB +: TM_W]);
            err_q   <= dec_next_reserved(cfg_wdata[CODE_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= mk_ent(1'b0, SRC_AP);
            start_q <= 1'b0;
            res_q   <= '0;
        end else if (take) begin
            sel_q   <= dec.ent[idx];
            start_q <= (idx == '0);
            res_q   <= word;
        end else begin
            start_q <= 1'b0;
        end
    end

    function automatic logic dec_next_reserved(input logic [CODE_W-1:0] c);
        unique case (c)
            5'b00000, 5'b00001, 5'b00010, 5'b00011, 5'b00100, 5'b00101,
            5'b10001, 5'b10010, 5'b10011, 5'b10101, 5'b10110, 5'b11001:
                return 1'b0;
            default:
                return 1'b1;
        endcase
    endfunction

    assign sel_src   = sel_q.src;
    assign sel_diff  = sel_q.diff;
    assign seq_start = start_q;
    assign result    = res_q;
    assign cfg_err   = err_q;

    // R8: the start flag only follows an accepted strobe
    assert_start_after_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        seq_start |-> $past(conv_strobe && !cfg_we));

    // R9: outputs hold when no strobe was accepted
    assert_hold_between_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(conv_strobe && !cfg_we) |->
            ($stable(sel_src) && $stable(sel_diff) && $stable(result)));

    // R3: differential selections only name the pair's positive input
    assert_diff_pair_R3: assert property (@(posedge clk) disable iff (rst)
        sel_diff |-> !sel_src[0]);

    // R6: the error flag moves only after a register write
    assert_err_on_write_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_err) |-> $past(cfg_we));

    // R6: reserved code reports single-ended A+
    assert_reserved_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg_err && $past(conv_strobe && !cfg_we)) |-> (sel_src == 2'd0 && !sel_diff));

    // R10: positive-reference test word is all ones
    assert_test_pos_R10: assert property (@(posedge clk) disable iff (rst)
        $past(conv_strobe && !cfg_we && tmode_q == TM_POS) |-> (result == '1));
endmodule

// File: tb/tb_adc_scan_seq.sv
module tb_adc_scan_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_wdata = '0;
    logic        conv_strobe = 1'b0;
    logic [11:0] raw_data = '0;
    logic [1:0]  sel_src;
    logic        sel_diff;
    logic        seq_start;
    logic [11:0] result;
    logic        cfg_err;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // model state
    int m_code = 0, m_tm = 0, m_idx = 0;
    int m_sel = 0, m_start = 0, m_res = 0, m_err = 0;
    int seq[$];
    string ptag = "R1";

    always #10 clk = ~clk;

    adc_scan_seq dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .conv_strobe(conv_strobe), .raw_data(raw_data), .sel_src(sel_src),
        .sel_diff(sel_diff), .seq_start(seq_start), .result(result), .cfg_err(cfg_err)
    );

    // entry encoding in the model: diff*4 + input number
    function automatic bit load_seq(int code);
        case (code)
            5'b00000: seq = '{0};
            5'b00001: seq = '{1};
            5'b00010: seq = '{2};
            5'b00011: seq = '{3};
            5'b00100: seq = '{4};
            5'b00101: seq = '{6};
            5'b10001: seq = '{0, 1};
            5'b10010: seq = '{0, 1, 2};
            5'b10011: seq = '{0, 1, 2, 3};
            5'b10101: seq = '{0, 6};
            5'b10110: seq = '{0, 1, 6};
            5'b11001: seq = '{4, 6};
            default: begin seq = '{0}; return 1'b1; end
        endcase
        return 1'b0;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all(string seltag);
        chk(seltag, {29'd0, sel_diff, sel_src}, m_sel);
        chk("R8", int'(seq_start), m_start);
        chk("R10", int'(result), m_res);
        chk("R6", int'(cfg_err), m_err);
    endtask

    // one cycle: inputs are set at a falling edge, model updates at the rising edge,
    // outputs are compared at the following falling edge
    task automatic cyc(bit we, int wd, bit st, int raw);
        cfg_we      = we;
        cfg_wdata   = 7'(wd);
        conv_strobe = st;
        raw_data    = 12'(raw);
        @(posedge clk);
        if (we) begin
            m_code  = wd & 31;
            m_tm    = (wd >> 5) & 3;
            m_idx   = 0;
            m_err   = load_seq(m_code);
            m_start = 0;
        end else if (st) begin
            m_sel   = seq[m_idx];
            m_start = (m_idx == 0);
            case (m_tm)
                1: m_res = 'hFFF;
                2: m_res = 'h800;
                3: m_res = 'h000;
                default: m_res = raw & 'hFFF;
            endcase
            m_idx = (m_idx + 1) % seq.size();
        end else begin
            m_start = 0;
        end
        @(negedge clk);
        compare_all((!we && !st) ? "R9" : ptag);
    endtask

    task automatic run_code(string tag, int wd, int n, int gap);
        int r;
        ptag = tag;
        cyc(1'b1, wd, 1'b0, 0);
        for (int i = 0; i < n; i++) begin
            r = (i * 'h1A7 + wd * 'h35 + 'h5C) & 'hFFF;
            cyc(1'b0, 0, 1'b1, r);
            for (int g = 0; g < gap; g++) cyc(1'b0, 0, 1'b0, 'hABC);
        end
    endtask

    initial begin
        void'(load_seq(0));
        repeat (5) @(negedge clk);
        ptag = "R1";
        compare_all("R1");
        rst = 1'b0;
        cyc(1'b0, 0, 1'b0, 0);

        // fixed single-ended and differential selections
        for (int c = 0; c < 4; c++) run_code("R2", c, 3, 0);
        run_code("R3", 5'b00100, 3, 1);
        run_code("R3", 5'b00101, 3, 0);

        // autoscan orders
        run_code("R4", 5'b10001, 5, 1);
        run_code("R4", 5'b10010, 7, 0);
        run_code("R4", 5'b10011, 9, 2);
        run_code("R5", 5'b10101, 5, 0);
        run_code("R5", 5'b10110, 7, 1);
        run_code("R5", 5'b11001, 5, 0);

        // reserved codes, then a valid code clears the flag
        run_code("R6", 5'b00110, 3, 0);
        run_code("R6", 5'b11111, 3, 1);
        run_code("R6", 5'b01000, 2, 0);
        run_code("R6", 5'b10011, 2, 0);

        // restart on write, strobe coinciding with a write is ignored
        ptag = "R7";
        run_code("R7", 5'b10011, 3, 0);
        cyc(1'b1, 5'b10011, 1'b1, 'h123);
        cyc(1'b0, 0, 1'b1, 'h321);
        cyc(1'b0, 0, 1'b1, 'h222);
        cyc(1'b1, 5'b10010, 1'b0, 0);
        cyc(1'b0, 0, 1'b1, 'h0F0);

        // test-mode words
        for (int t = 0; t < 4; t++) run_code("R10", (t << 5) | 5'b10010, 4, 1);
        run_code("R10", 5'b00000, 3, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule